// File: doc/BRIEF.md
# Keyed Windowed Watchdog

A watchdog counter that software keeps alive by writing one fixed key byte into a service register. Each valid key write clears the count and starts a new interval. If the count reaches the programmed overflow limit, the block raises a one-cycle internal reset request. It also raises one for any write that breaks the servicing rules: a wrong key, a single-bit read-modify-write access, or a key that arrives while the service window is still closed.

Static configuration inputs set the overflow interval, the fraction of the interval during which servicing is allowed, and whether the counter keeps running while the system is in halt or stop. The first valid service after reset, or after a reset request, may arrive at any point before overflow. A read of the service register returns a fixed status byte, which is never the key.

Top module: `kwdog_top`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `rst_req` is 0. The counter starts at 0 and the first-service exemption is armed.
- R2: A write of 0xAC with `wr_bitop`=0 that is accepted clears the count. Without further service, `rst_req` then pulses exactly L clock edges after the write edge, where L is the overflow length.
- R3: A write of any byte other than 0xAC sets `rst_req` on the write edge.
- R4: A write with `wr_bitop`=1 sets `rst_req` on the write edge, even when `wr_data` is 0xAC.
- R5: `rd_data` is 0x9A when `cfg_stby_run`=1 and 0x1A when it is 0. It never equals 0xAC.
- R6: While the first-service exemption is armed, a valid key is accepted at any count value.
- R7: After the first service, a valid key is accepted only when the count is at or above the window start. Otherwise it sets `rst_req`. The window start is L − (L/4)·(k+1), where k = `cfg_win_sel` (0 gives 25%, 1 gives 50%, 2 gives 75%); `cfg_win_sel`=3 makes the window start 0.
- R8: L = 2^(BASE_EXP + `cfg_ovf_sel`). With no service, `rst_req` is set on the L-th counting edge. A valid key written when the count is L−1 is still accepted.
- R9: When `cfg_stby_run`=0, the window start is 0 whatever `cfg_win_sel` holds.
- R10: When `cfg_stby_run`=0 and `halt` or `stop` is 1, the count holds. On the first edge with both inputs low again, the count is cleared to 0.
- R11: When `cfg_stby_run`=1, the count keeps advancing during `halt` or `stop`.
- R12: `rst_req` is high for one cycle. The same edge clears the count and re-arms the first-service exemption.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_ovf_sel | input | 3 | Overflow exponent offset n, giving L = 2^(BASE_EXP+n) |
| cfg_win_sel | input | 2 | Window open fraction: 0=25%, 1=50%, 2=75%, 3=100% |
| cfg_stby_run | input | 1 | 1: count during standby; 0: pause in standby and open the window fully |
| halt | input | 1 | System in halt |
| stop | input | 1 | System in stop |
| wr_en | input | 1 | Write strobe for the service register |
| wr_data | input | 8 | Write data |
| wr_bitop | input | 1 | Marks the write as a single-bit manipulation access |
| rd_data | output | 8 | Read-back value of the service register |
| rst_req | output | 1 | One-cycle internal reset request |

## Verification
The assertions assume that the configuration inputs stay constant between resets. A change of overflow limit in the middle of an interval would move the wrap point under a running count. They also assume that no write arrives in the cycle right after a reset request. The stimulus sets the configuration only while `rst_n` is low. Every write and every change to halt or stop is driven on a falling edge, several cycles clear of any expected reset pulse.

// File: rtl/kwdog_pkg.sv
package kwdog_pkg;

   typedef enum logic [1:0] {
      WIN_Q1   = 2'd0,
      WIN_Q2   = 2'd1,
      WIN_Q3   = 2'd2,
      WIN_FULL = 2'd3
   } win_sel_e;

   localparam logic [7:0] SVC_KEY     = 8'hAC;
   localparam logic [7:0] RD_STBY_ON  = 8'h9A;
   localparam logic [7:0] RD_STBY_OFF = 8'h1A;

endpackage

// File: rtl/kwdog_limits.sv
module kwdog_limits #(
   parameter int BASE_EXP  = 7,
   parameter int SEL_W     = 3,
   parameter int CNT_W     = BASE_EXP + (1 << SEL_W),
   parameter bit WINDOW_EN = 1'b1
) (
   input  logic [SEL_W-1:0] cfg_ovf_sel,
   input  logic [1:0]       cfg_win_sel,
   input  logic             cfg_stby_run,
   output logic [CNT_W-1:0] lim_m1,
   output logic [CNT_W-1:0] win_start
);
   import kwdog_pkg::*;

   localparam int FW = CNT_W + 1;

   if (BASE_EXP < 2) begin : g_chk_base
      $error("kwdog_limits: BASE_EXP must be at least 2");
   end
   if (CNT_W < BASE_EXP + (1 << SEL_W)) begin : g_chk_w
      $error("kwdog_limits: CNT_W too small for the largest interval");
   end

   logic [FW-1:0] lim_full;
   logic [FW-1:0] quarter;

   always_comb begin
      lim_full = FW'(1) << (BASE_EXP + int'(cfg_ovf_sel));
      quarter  = lim_full >> 2;
      lim_m1   = CNT_W'(lim_full - FW'(1));
   end

   if (WINDOW_EN) begin : g_window
      logic [FW-1:0] start_full;
      always_comb begin
         unique case (win_sel_e'(cfg_win_sel))
            WIN_Q1:   start_full = lim_full - quarter;
            WIN_Q2:   start_full = lim_full - (quarter << 1);
            WIN_Q3:   start_full = lim_full - (quarter << 1) - quarter;
            default:  start_full = '0;
         endcase
         if (!cfg_stby_run)
            start_full = '0;
         win_start = CNT_W'(start_full);
      end
   end else begin : g_open
      logic unused_win;
      assign unused_win = ^{cfg_win_sel, cfg_stby_run};
      assign win_start  = '0;
   end

endmodule

// File: rtl/kwdog_keychk.sv
module kwdog_keychk #(
   parameter int CNT_W = 15
) (
   input  logic             wr_en,
   input  logic [7:0]       wr_data,
   input  logic             wr_bitop,
   input  logic             first_pend,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] win_start,
   output logic             svc_ok,
   output logic             key_fault
);
   import kwdog_pkg::*;

   logic bad_access;
   logic too_early;

   always_comb begin
      bad_access = wr_bitop || (wr_data != SVC_KEY);
      too_early  = !first_pend && (cnt < win_start);
      key_fault  = wr_en && (bad_access || too_early);
      svc_ok     = wr_en && !bad_access && !too_early;
   end

endmodule

// File: rtl/kwdog_counter.sv
module kwdog_counter #(
   parameter int CNT_W = 15
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr_i,
   input  logic             pause_i,
   input  logic [CNT_W-1:0] lim_m1_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);
   logic [CNT_W-1:0] cnt_q;
   logic             pause_d;
   logic             resume;

   assign resume = pause_d && !pause_i;
   assign wrap_o = (cnt_q == lim_m1_i) && !pause_i && !resume;
   assign cnt_o  = cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         pause_d <= 1'b0;
      end else begin
         pause_d <= pause_i;
         if (clr_i || resume)
            cnt_q <= '0;
         else if (!pause_i)
            cnt_q <= cnt_q + CNT_W'(1);
      end
   end

   assert_pause_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pause_i && pause_d && !clr_i) |=> $stable(cnt_q))
      else $error("count moved while paused");

   assert_resume_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (pause_d && !pause_i) |=> (cnt_q == '0))
      else $error("count not cleared on standby release");

endmodule

// File: rtl/kwdog_top.sv
module kwdog_top #(
   parameter int BASE_EXP  = 7,
   parameter int SEL_W     = 3,
   parameter bit WINDOW_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] cfg_ovf_sel,
   input  logic [1:0]       cfg_win_sel,
   input  logic             cfg_stby_run,
   input  logic             halt,
   input  logic             stop,
   input  logic             wr_en,
   input  logic [7:0]       wr_data,
   input  logic             wr_bitop,
   output logic [7:0]       rd_data,
   output logic             rst_req
);
   import kwdog_pkg::*;

   localparam int CNT_W = BASE_EXP + (1 << SEL_W);

   if (SEL_W < 1 || SEL_W > 4) begin : g_chk_sel
      $error("kwdog_top: SEL_W must lie in 1..4");
   end

   logic [CNT_W-1:0] lim_m1;
   logic [CNT_W-1:0] win_start;
   logic [CNT_W-1:0] cnt;
   logic             wrap;
   logic             svc_ok;
   logic             key_fault;
   logic             fault;
   logic             paused;
   logic             first_pend;

   assign paused  = (halt || stop) && !cfg_stby_run;
   assign fault   = key_fault || (wrap && !svc_ok);
   assign rd_data = cfg_stby_run ? RD_STBY_ON : RD_STBY_OFF;

   kwdog_limits #(
      .BASE_EXP (BASE_EXP),
      .SEL_W    (SEL_W),
      .CNT_W    (CNT_W),
      .WINDOW_EN(WINDOW_EN)
   ) u_limits (
      .cfg_ovf_sel (cfg_ovf_sel),
      .cfg_win_sel (cfg_win_sel),
      .cfg_stby_run(cfg_stby_run),
      .lim_m1      (lim_m1),
      .win_start   (win_start)
   );

   kwdog_keychk #(.CNT_W(CNT_W)) u_keychk (
      .wr_en     (wr_en),
      .wr_data   (wr_data),
      .wr_bitop  (wr_bitop),
      .first_pend(first_pend),
      .cnt       (cnt),
      .win_start (win_start),
      .svc_ok    (svc_ok),
      .key_fault (key_fault)
   );

   kwdog_counter #(.CNT_W(CNT_W)) u_counter (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (fault || svc_ok),
      .pause_i (paused),
      .lim_m1_i(lim_m1),
      .cnt_o   (cnt),
      .wrap_o  (wrap)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_req    <= 1'b0;
         first_pend <= 1'b1;
      end else begin
         rst_req <= fault;
         if (fault)
            first_pend <= 1'b1;
         else if (svc_ok)
            first_pend <= 1'b0;
      end
   end

   assert_badkey_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_data != SVC_KEY) |=> rst_req)
      else $error("wrong key did not request reset");

   assert_bitop_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_bitop) |=> rst_req)
      else $error("bit access did not request reset");

   assert_first_free_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_bitop && wr_data == SVC_KEY && first_pend) |=> !rst_req)
      else $error("first service rejected");

   assert_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wrap && !wr_en) |=> rst_req)
      else $error("overflow without reset request");

   assert_post_fault_R12: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req |-> (cnt == '0 && first_pend))
      else $error("state not restored with reset request");

   always_comb begin
      assert_readback_R5: assert (rd_data != SVC_KEY)
         else $error("read-back equals key");
   end

endmodule

// File: tb/sim_kwdog_top.sv
`timescale 1ns/1ps
module sim_kwdog_top;

   localparam int BEXP = 4;
   localparam int L0   = 1 << BEXP;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] cfg_ovf_sel = 3'd0;
   logic [1:0] cfg_win_sel = 2'd3;
   logic       cfg_stby_run = 1'b1;
   logic       halt = 1'b0;
   logic       stop = 1'b0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = 8'h00;
   logic       wr_bitop = 1'b0;
   logic [7:0] rd_data;
   logic       rst_req;

   int checks = 0;
   int errors = 0;
   int cyc = 0;
   int base = 0;
   bit finished = 1'b0;

   typedef struct {
      int    at;
      logic  exp;
      string tag;
   } exp_item_t;

   exp_item_t sb[$];

   always #2 clk = ~clk;

   kwdog_top #(.BASE_EXP(BEXP), .SEL_W(3), .WINDOW_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .cfg_ovf_sel(cfg_ovf_sel),
      .cfg_win_sel(cfg_win_sel), .cfg_stby_run(cfg_stby_run),
      .halt(halt), .stop(stop), .wr_en(wr_en), .wr_data(wr_data),
      .wr_bitop(wr_bitop), .rd_data(rd_data), .rst_req(rst_req)
   );

   always @(posedge clk) cyc <= cyc + 1;

   task automatic chk(input logic [7:0] act, input logic [7:0] expv, input string tag);
      checks++;
      if (act !== expv) begin
         errors++;
         $display("FAIL %s: actual %h expected %h (edge %0d)", tag, act, expv, cyc);
      end
   endtask

   // monitor: pops scoreboard items when their edge has been reached
   always @(negedge clk) begin
      while (sb.size() > 0 && sb[0].at <= cyc) begin
         exp_item_t it;
         it = sb.pop_front();
         if (it.at < cyc) begin
            checks++;
            errors++;
            $display("FAIL %s: actual missed expected sample at edge %0d", it.tag, it.at);
         end else
            chk({7'd0, rst_req}, {7'd0, it.exp}, it.tag);
      end
   end

   task automatic expect_at(input int at, input logic v, input string tag);
      exp_item_t it;
      it.at = at; it.exp = v; it.tag = tag;
      sb.push_back(it);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset(input logic [2:0] ovf, input logic [1:0] win, input logic sr);
      @(negedge clk);
      rst_n = 1'b0;
      wr_en = 1'b0;
      cfg_ovf_sel = ovf;
      cfg_win_sel = win;
      cfg_stby_run = sr;
      idle(2);
      chk({7'd0, rst_req}, 8'd0, "R1 reset held");
      rst_n = 1'b1;
      base = cyc;
   endtask

   // drive one write on the next edge; returns that edge index
   task automatic write(input logic [7:0] d, input logic bop, output int w);
      w = cyc + 1;
      wr_en = 1'b1;
      wr_data = d;
      wr_bitop = bop;
      @(negedge clk);
      wr_en = 1'b0;
      wr_bitop = 1'b0;
   endtask

   task automatic drain();
      wait (sb.size() == 0);
      @(negedge clk);
   endtask

   initial begin
      int w1, w2, w3, r;

      // R1 and R5: reset state and read-back
      do_reset(3'd0, 2'd3, 1'b1);
      expect_at(base + 1, 1'b0, "R1 first edge");
      chk(rd_data, 8'h9A, "R5 standby run");
      drain();

      // R8 and R12: overflow, pulse width
      do_reset(3'd0, 2'd3, 1'b1);
      expect_at(base + L0 - 1, 1'b0, "R8 before limit");
      expect_at(base + L0, 1'b1, "R8 at limit");
      expect_at(base + L0 + 1, 1'b0, "R12 single pulse");
      drain();

      // R8: larger interval
      do_reset(3'd1, 2'd3, 1'b1);
      expect_at(base + 2*L0 - 1, 1'b0, "R8 sel1 before");
      expect_at(base + 2*L0, 1'b1, "R8 sel1 limit");
      drain();

      // R6 and R2: first service in closed 25% window
      do_reset(3'd0, 2'd0, 1'b1);
      idle(2);
      expect_at(cyc + 1, 1'b0, "R6 early first key");
      write(8'hAC, 1'b0, w1);
      expect_at(w1 + L0 - 1, 1'b0, "R2 restart before");
      expect_at(w1 + L0, 1'b1, "R2 restart overflow");
      drain();

      // R7: second key one below window start (12), then R12 re-armed exemption
      do_reset(3'd0, 2'd0, 1'b1);
      write(8'hAC, 1'b0, w1);
      idle(11);
      expect_at(cyc + 1, 1'b1, "R7 closed window");
      write(8'hAC, 1'b0, w2);
      idle(2);
      expect_at(cyc + 1, 1'b0, "R12 exemption re-armed");
      write(8'hAC, 1'b0, w3);
      drain();

      // R7: second key exactly at window start
      do_reset(3'd0, 2'd0, 1'b1);
      write(8'hAC, 1'b0, w1);
      idle(12);
      expect_at(cyc + 1, 1'b0, "R7 open window");
      write(8'hAC, 1'b0, w2);
      expect_at(w2 + L0, 1'b1, "R7 overflow after");
      drain();

      // R8: key at count L-1 accepted
      do_reset(3'd0, 2'd0, 1'b1);
      write(8'hAC, 1'b0, w1);
      idle(L0 - 1);
      expect_at(cyc + 1, 1'b0, "R8 last-cycle service");
      write(8'hAC, 1'b0, w2);
      expect_at(w2 + L0, 1'b1, "R8 after last service");
      drain();

      // R3: wrong key
      do_reset(3'd0, 2'd3, 1'b1);
      idle(3);
      expect_at(cyc + 1, 1'b1, "R3 wrong key");
      expect_at(cyc + 2, 1'b0, "R12 pulse end");
      write(8'h55, 1'b0, w1);
      drain();

      // R4: bit access with key value
      do_reset(3'd0, 2'd3, 1'b1);
      idle(1);
      expect_at(cyc + 1, 1'b1, "R4 bit access");
      write(8'hAC, 1'b1, w1);
      drain();

      // R9 and R5: standby off opens the window
      do_reset(3'd0, 2'd0, 1'b0);
      chk(rd_data, 8'h1A, "R5 standby off");
      write(8'hAC, 1'b0, w1);
      idle(1);
      expect_at(cyc + 1, 1'b0, "R9 forced open");
      write(8'hAC, 1'b0, w2);
      expect_at(w2 + L0, 1'b1, "R9 overflow after");
      drain();

      // R10: pause in stop, clear on release
      do_reset(3'd0, 2'd3, 1'b0);
      idle(5);
      stop = 1'b1;
      expect_at(base + L0, 1'b0, "R10 paused at limit");
      expect_at(base + L0 + 10, 1'b0, "R10 still paused");
      idle(30);
      stop = 1'b0;
      r = cyc + 1;
      expect_at(r + L0 - 1, 1'b0, "R10 cleared on release");
      expect_at(r + L0, 1'b1, "R10 overflow after release");
      drain();

      // R11: standby run counts through halt
      halt = 1'b1;
      do_reset(3'd0, 2'd3, 1'b1);
      expect_at(base + L0, 1'b1, "R11 counts in halt");
      drain();
      halt = 1'b0;

      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule